// File: doc/BRIEF.md
# Link Bus Handover Controller

This block sits on the PHY side of a two-wire control handshake between a physical layer and a link layer. When the PHY decides to let the link transmit, it drives a grant code for one cycle and then an idle code for one cycle. After that it tri-states both the control pair and the 8-bit data bus, so the link owns them. The block then watches the codes the link drives and recognises a cancelled (null) transmit. That is a short, bounded run of idle and hold codes after which the link hands the bus back.

Once the cancel sequence ends, the PHY takes the bus back in the very next cycle and drives idle. It reports one of two one-cycle outcomes: a clean null completion, or a protocol error. Any code sequence outside the permitted shape is an error. Examples are an over-long hold run, a code the link must never drive, or a hold after the closing idles have started. An error also ends link ownership at once.

The cancel window has two legal shapes. In the first, the link drives one or more hold cycles (at most 47, optionally preceded by one idle) and then two idles. In the second, the link drives no hold at all and ends with exactly three idles. Exactly three are required because, without a hold, two idles alone cannot be told apart from the optional leading idle followed by the start of the closing pair.

Top module: `link_handover_ctrl`

## Requirements
- R1: A grant request seen while the PHY is idle produces, in the following cycles: one cycle of code 11 (grant), then one cycle of code 00 (idle), both with the control and data enables high. From the third cycle on, both enables are low for as long as the link owns the bus. The two enables are always equal.
- R2: After reset the PHY owns the bus. Both enables are high, the control output is 00, and both status pulses are low.
- R3: Link codes are 00 idle and 01 hold. A window of an optional single idle, then 1 to 47 holds, then two idles completes a null transmit. The PHY regains the bus in the cycle after the second closing idle.
- R4: Up to 47 consecutive holds are accepted. The 48th consecutive hold raises a protocol error, and the PHY owns the bus in the next cycle.
- R5: A window with no hold completes only after exactly three idles. Two idles followed by a hold is a protocol error, because the optional leading idle may be used at most once.
- R6: In the first cycle after the PHY regains the bus, it drives idle (00) with the enables high, even if a grant request is pending. A pending request produces grant in the cycle after that.
- R7: A link code of 10 or 11 during link ownership is a protocol error and returns the bus to the PHY.
- R8: The null-done and protocol-error outputs each pulse for exactly one cycle, in the first PHY-owned cycle after the window ends. They never pulse together, and an error never produces a null-done.
- R9: A hold after one of the closing idles (hold, idle, hold) is a protocol error.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| xmit_req | input | 1 | Request to hand the bus to the link for one transmit |
| link_ctl | input | 2 | Control code driven by the link |
| phy_ctl | output | 2 | Control code driven by the PHY (valid when enabled) |
| phy_ctl_oe | output | 1 | PHY control-pair output enable |
| phy_d_oe | output | 1 | PHY data-bus output enable |
| null_done | output | 1 | One-cycle pulse: null transmit completed, bus returned |
| proto_err | output | 1 | One-cycle pulse: illegal link sequence, bus reclaimed |

## Verification
The bench targets the edges of the hold counter with runs of 47 and 48 holds. A counter off by one would either reject a legal 47-hold cancel or accept an overlong one. The no-hold cancel is driven both as three idles and as two idles followed by a hold. A design that closed on two idles would hand the bus back a cycle early, leaving a cycle in which both sides drive. Back-to-back requests check that the return cycle always drives idle, since a design that forwarded the pending request at once would place a grant with no idle spacing. Illegal codes and a hold after a closing idle check that errors end ownership and never also report completion.

// File: rtl/hx_pkg.sv
package hx_pkg;
  localparam logic [1:0] CODE_IDLE  = 2'b00;
  localparam logic [1:0] CODE_HOLD  = 2'b01;
  localparam logic [1:0] CODE_GRANT = 2'b11;

  typedef enum logic [1:0] {
    ST_PHY_IDLE = 2'd0,
    ST_GRANT    = 2'd1,
    ST_HANDOFF  = 2'd2,
    ST_LINK     = 2'd3
  } hx_state_e;
endpackage

// File: rtl/hx_hold_counter.sv
module hx_hold_counter #(
  parameter int MAX_HOLD = 47,
  localparam int CW = $clog2(MAX_HOLD + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          inc,
  output logic [CW-1:0] count,
  output logic          full
);
  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = clr | (inc & ~full);
    cnt_d  = clr ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign count = cnt_q;
  assign full  = (cnt_q == CW'(MAX_HOLD));

  AST_HOLD_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(MAX_HOLD)); // R4
endmodule

// File: rtl/hx_cancel_judge.sv
module hx_cancel_judge
  import hx_pkg::*;
#(
  parameter int MAX_HOLD = 47
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic       active,
  input  logic [1:0] code,
  output logic       done,
  output logic       err
);
  localparam int CW = $clog2(MAX_HOLD + 1);

  logic [1:0]    idle_run_q, idle_run_d;
  logic          got_hold_q, got_hold_d;
  logic          run_en;
  logic          is_idle, is_hold;
  logic          hold_full;
  logic [CW-1:0] hold_cnt;

  hx_hold_counter #(.MAX_HOLD(MAX_HOLD)) u_hold (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (clr),
    .inc   (active & is_hold),
    .count (hold_cnt),
    .full  (hold_full)
  );

  always_comb begin
    is_idle = (code == CODE_IDLE);
    is_hold = (code == CODE_HOLD);
    done = 1'b0;
    err  = 1'b0;
    if (active) begin
      if (is_idle) begin
        done = got_hold_q ? (idle_run_q == 2'd1) : (idle_run_q == 2'd2);
      end else if (is_hold) begin
        err = (got_hold_q && idle_run_q != 2'd0) ||
              (!got_hold_q && idle_run_q > 2'd1) || hold_full;
      end else begin
        err = 1'b1;
      end
    end
  end

  always_comb begin
    run_en     = clr | active;
    idle_run_d = idle_run_q;
    got_hold_d = got_hold_q;
    if (clr) begin
      idle_run_d = 2'd0;
      got_hold_d = 1'b0;
    end else if (is_idle) begin
      idle_run_d = (idle_run_q == 2'd3) ? idle_run_q : idle_run_q + 2'd1;
    end else if (is_hold) begin
      idle_run_d = 2'd0;
      got_hold_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idle_run_q <= 2'd0;
      got_hold_q <= 1'b0;
    end else if (run_en) begin
      idle_run_q <= idle_run_d;
      got_hold_q <= got_hold_d;
    end
  end

  AST_ONE_VERDICT: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && err)); // R8
  AST_HOLD_NEEDS_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    (active && got_hold_q) |-> (hold_cnt != '0)); // R3
endmodule

// File: rtl/link_handover_ctrl.sv
module link_handover_ctrl
  import hx_pkg::*;
#(
  parameter int MAX_HOLD = 47
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       xmit_req,
  input  logic [1:0] link_ctl,
  output logic [1:0] phy_ctl,
  output logic       phy_ctl_oe,
  output logic       phy_d_oe,
  output logic       null_done,
  output logic       proto_err
);
  hx_state_e state_q, state_d;
  logic      win_done, win_err;
  logic      done_q, err_q;
  logic      in_link;

  assign in_link = (state_q == ST_LINK);

  hx_cancel_judge #(.MAX_HOLD(MAX_HOLD)) u_judge (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (state_q == ST_HANDOFF),
    .active (in_link),
    .code   (link_ctl),
    .done   (win_done),
    .err    (win_err)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_PHY_IDLE: if (xmit_req) state_d = ST_GRANT;
      ST_GRANT:    state_d = ST_HANDOFF;
      ST_HANDOFF:  state_d = ST_LINK;
      ST_LINK:     if (win_done || win_err) state_d = ST_PHY_IDLE;
      default:     state_d = ST_PHY_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_PHY_IDLE;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= in_link & win_done;
      err_q   <= in_link & win_err;
    end
  end

  assign phy_ctl    = (state_q == ST_GRANT) ? CODE_GRANT : CODE_IDLE;
  assign phy_ctl_oe = ~in_link;
  assign phy_d_oe   = ~in_link;
  assign null_done  = done_q;
  assign proto_err  = err_q;

  AST_GRANT_THEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (phy_ctl == CODE_GRANT) |=> (phy_ctl_oe && phy_ctl == CODE_IDLE)); // R1
  AST_HANDOFF_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (phy_ctl_oe && $past(phy_ctl) == CODE_GRANT) |=> !phy_ctl_oe); // R1
  AST_RETURN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(phy_ctl_oe) |-> (phy_ctl == CODE_IDLE)); // R6
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    null_done |=> !null_done); // R8
  AST_ERR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    proto_err |=> !proto_err); // R8
  AST_STATUS_ON_RETURN: assert property (@(posedge clk) disable iff (!rst_n)
    (null_done || proto_err) |-> ($rose(phy_ctl_oe) && phy_ctl == CODE_IDLE)); // R6
endmodule

// File: tb/link_handover_ctrl_bench.sv
module link_handover_ctrl_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       xmit_req;
  logic [1:0] link_ctl;
  logic [1:0] phy_ctl;
  logic       phy_ctl_oe, phy_d_oe, null_done, proto_err;
  int         n_chk = 0;
  int         n_bad = 0;

  always #4 clk = ~clk;

  link_handover_ctrl u_link_handover_ctrl (
    .clk(clk), .rst_n(rst_n), .xmit_req(xmit_req), .link_ctl(link_ctl),
    .phy_ctl(phy_ctl), .phy_ctl_oe(phy_ctl_oe), .phy_d_oe(phy_d_oe),
    .null_done(null_done), .proto_err(proto_err)
  );

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic phy_state(input string tag, input int ctl, input int dn, input int er);
    check({tag, " oe"}, phy_ctl_oe, 1);
    check({tag, " d_oe"}, phy_d_oe, 1);
    check({tag, " ctl"}, phy_ctl, ctl);
    check({tag, " done"}, null_done, dn);
    check({tag, " err"}, proto_err, er);
  endtask

  // Starts a transmit; returns at the negedge of the first link-owned cycle.
  task automatic xmit_start(input bit keep_req);
    xmit_req = 1'b1;
    @(negedge clk);
    check("R1 grant code", phy_ctl, 3);
    check("R1 grant oe", phy_ctl_oe, 1);
    xmit_req = keep_req;
    @(negedge clk);
    check("R1 handoff idle", phy_ctl, 0);
    check("R1 handoff oe", phy_ctl_oe & phy_d_oe, 1);
    xmit_req = 1'b0;
    @(negedge clk);
    check("R1 link owns ctl", phy_ctl_oe, 0);
    check("R1 link owns d", phy_d_oe, 0);
  endtask

  task automatic link_code(input logic [1:0] c);
    link_ctl = c;
    @(negedge clk);
    link_ctl = 2'b00;
  endtask

  task automatic holds(input int n);
    for (int i = 0; i < n; i++) begin
      link_code(2'b01);
      if (i < n - 1 || n < 48) check("R4 still link owned", phy_ctl_oe, 0);
    end
  endtask

  task automatic t_reset();
    phy_state("R2 reset", 0, 0, 0);
  endtask

  task automatic t_hold_cancel(input bit lead, input int n);
    xmit_start(1'b0);
    if (lead) begin
      link_code(2'b00);
      check("R3 lead idle keeps link", phy_ctl_oe, 0);
    end
    holds(n);
    link_code(2'b00);
    check("R3 one closing idle not done", phy_ctl_oe, 0);
    link_code(2'b00);
    phy_state("R3 returned", 0, 1, 0);
    @(negedge clk);
    phy_state("R8 done single pulse", 0, 0, 0);
  endtask

  task automatic t_three_idle();
    xmit_start(1'b0);
    link_code(2'b00);
    link_code(2'b00);
    check("R5 two idles still link", phy_ctl_oe, 0);
    check("R5 no early done", null_done, 0);
    link_code(2'b00);
    phy_state("R5 three idle return", 0, 1, 0);
    @(negedge clk);
  endtask

  task automatic t_two_idle_hold();
    xmit_start(1'b0);
    link_code(2'b00);
    link_code(2'b00);
    link_code(2'b01);
    phy_state("R5 idle idle hold err", 0, 0, 1);
    @(negedge clk);
    phy_state("R8 err single pulse", 0, 0, 0);
  endtask

  task automatic t_overflow();
    xmit_start(1'b0);
    holds(47);
    check("R4 47 holds fine", proto_err, 0);
    link_code(2'b01);
    phy_state("R4 48th hold err", 0, 0, 1);
    @(negedge clk);
  endtask

  task automatic t_bad_code(input logic [1:0] c, input bit pre_hold);
    xmit_start(1'b0);
    if (pre_hold) link_code(2'b01);
    link_code(c);
    phy_state("R7 illegal code", 0, 0, 1);
    @(negedge clk);
  endtask

  task automatic t_hold_after_idle();
    xmit_start(1'b0);
    link_code(2'b01);
    link_code(2'b00);
    link_code(2'b01);
    phy_state("R9 hold after closing idle", 0, 0, 1);
    @(negedge clk);
  endtask

  task automatic t_back_to_back();
    xmit_start(1'b0);
    link_code(2'b01);
    link_code(2'b00);
    xmit_req = 1'b1;
    link_code(2'b00);
    phy_state("R6 return cycle idle", 0, 1, 0);
    xmit_start(1'b0);
    link_code(2'b00);
    link_code(2'b00);
    link_code(2'b00);
    phy_state("R6 second window done", 0, 1, 0);
    @(negedge clk);
  endtask

  initial begin
    #(8 * 200000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    xmit_req = 1'b0;
    link_ctl = 2'b00;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_hold_cancel(1'b0, 1);
    t_hold_cancel(1'b1, 5);
    t_hold_cancel(1'b0, 47);
    t_three_idle();
    t_two_idle_hold();
    t_overflow();
    t_bad_code(2'b10, 1'b0);
    t_bad_code(2'b11, 1'b1);
    t_hold_after_idle();
    t_back_to_back();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule